// File: doc/BRIEF.md
# JESD204B Transmit Link Startup Sequencer

This block is the link-layer controller for one transmit lane. Each clock it hands one octet, with a flag that marks it as a control character, to a downstream 8b/10b encoder. It keeps a local multiframe clock (LMFC) as a pair of octet and frame counters, and it watches the active-low sync request from the receiver.

While the receiver holds the request, the lane sends code-group synchronization characters. After the request is released, the lane waits for a multiframe boundary, plus an optional extra delay of zero to three multiframes. It then sends the four-multiframe initial lane alignment (ILA) sequence and afterwards passes user octets straight through. The second ILA multiframe carries a 14-octet link configuration block. The block builds that configuration block, including its checksum, from static configuration inputs.

The ILA can be switched off. The idle code can be switched to a two-octet pair. The LMFC can start from a preset frame number when it comes out of reset. A sync request held for one frame or longer at any time returns the lane to code-group sync.

Top module: `jlss_link_seq`

## Requirements
- R1: In code-group sync and while waiting for the alignment start, with `idle_alt` low, every octet is K28.5 (`tx_octet`=BCh, `tx_is_k`=1). The lane is in code-group sync after reset and stays there while `sync_n` is low.
- R2: With `idle_alt` high, the sync code alternates BCh (control) and 50h (data). The alternation counts octets from reset, and it restarts with BCh on the first octet after a return to code-group sync.
- R3: Let the release be the first cycle in which `sync_n` is sampled high. The first ILA octet follows the first LMFC boundary that falls in a cycle at or after the release. When `ila_delay` is D, the start moves D×F×K octets later.
- R4: The ILA lasts exactly four multiframes. Each one opens with K28.0 (1Ch, control) and closes with K28.3 (7Ch, control). Any octet not otherwise defined carries `data_in`, flagged as data.
- R5: In the second ILA multiframe, octet index 1 is K28.4 (9Ch, control) and octet indices 2 to 15 are configuration octets 0 to 13, flagged as data.
- R6: Configuration octets, with bit 7 on the left and unused bits zero: 0 = DID; 1 = {0000, BID}; 2 = {000, LID}; 3 = {SCR, 00, L−1}; 4 = F−1; 5 = {000, K−1}; 6 = M−1; 7 = {CS, 0, N−1}; 8 = {subclass, N'−1}; 9 = {version, S−1}; 10 = {HD, 00, CF}; 11 and 12 = 00h.
- R7: Configuration octet 13 is the modulo-256 sum of every field value of octets 0 to 12, using the encoded minus-one values.
- R8: With `ila_off` high, user data starts at the point where the ILA would have started, and no ILA octets are sent.
- R9: The LMFC counts octets modulo F×K, with F = `cfg_f_m1`+1 and K = `cfg_k_m1`+1. `tx_mf_last` marks the last octet of each multiframe. If `lmfc_force` is high during reset, the first octet after reset is octet 0 of frame `lmfc_init`; otherwise it is octet 0 of frame 0.
- R10: Once the lane has left code-group sync, `sync_n` low for F consecutive cycles sends it back to code-group sync. The first sync octet is the one in the F-th low cycle. A low run shorter than F changes nothing.
- R11: After the ILA, each output octet is the `data_in` value of the previous cycle, flagged as data.
- R12: While `rst` is high, the outputs are BCh with `tx_is_k`=1 and `tx_mf_last`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low sync request from the receiver |
| data_in | input | 8 | User octet for the data phase and ILA filler |
| ila_off | input | 1 | Skip the alignment sequence |
| idle_alt | input | 1 | Use the BCh/50h sync pair |
| ila_delay | input | 2 | Extra multiframes before the ILA |
| lmfc_force | input | 1 | Preload the LMFC frame number at reset |
| lmfc_init | input | K_W | Preload frame number |
| cfg_f_m1 | input | F_W | Octets per frame minus one |
| cfg_k_m1 | input | K_W | Frames per multiframe minus one |
| cfg_did | input | 8 | Device identifier |
| cfg_bid | input | 4 | Bank identifier |
| cfg_lid | input | 5 | Lane identifier |
| cfg_scr | input | 1 | Scrambling flag for the configuration block |
| cfg_l_m1 | input | 5 | Lanes minus one |
| cfg_m_m1 | input | 8 | Converters minus one |
| cfg_cs | input | 2 | Control bits per sample |
| cfg_n_m1 | input | 5 | Resolution minus one |
| cfg_np_m1 | input | 5 | Bits per sample minus one |
| cfg_subclass | input | 3 | Subclass code |
| cfg_jesdv | input | 3 | Version code |
| cfg_s_m1 | input | 5 | Samples per frame minus one |
| cfg_hd | input | 1 | High-density flag |
| cfg_cf | input | 5 | Control words per frame |
| tx_octet | output | 8 | Octet to the encoder |
| tx_is_k | output | 1 | Octet is a control character |
| tx_mf_last | output | 1 | Octet is the last of its multiframe |

## Verification
The bench pins down the first ILA octet for releases that land just before, on and after a boundary, with preloaded LMFC phases and every extra delay. A design that started the ILA one multiframe early or late, or that counted the delay from the wrong boundary, would put K28.0 at the wrong octet. Configuration fields near their maximum force the checksum to wrap, which catches a sum that is not taken modulo 256 or that adds whole octets instead of field values. Sync request runs one octet shorter than a frame and exactly one frame long are applied in the data phase; an off-by-one counter either drops the link on a glitch or misses a real request. When F is 1, every single low cycle must count as a request.

// File: rtl/jlss_pkg.sv
package jlss_pkg;

    localparam logic [7:0] K_COMMA    = 8'hBC;
    localparam logic [7:0] K_MF_OPEN  = 8'h1C;
    localparam logic [7:0] K_MF_CLOSE = 8'h7C;
    localparam logic [7:0] K_CFG_MARK = 8'h9C;
    localparam logic [7:0] IDLE_PAIR  = 8'h50;

    localparam int CFG_OCTETS = 14;
    localparam int CFG_FIRST  = 2;
    localparam int CFG_LAST   = CFG_FIRST + CFG_OCTETS - 1;
    localparam int ILA_MFS    = 4;

    typedef enum logic [1:0] {
        SQ_CGS  = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_ILA  = 2'd2,
        SQ_DATA = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic [7:0] octet;
        logic       is_k;
        logic       mf_last;
    } lane_sym_t;

    typedef struct packed {
        logic [7:0] did;
        logic [3:0] bid;
        logic [4:0] lid;
        logic       scr;
        logic [4:0] l_m1;
        logic [7:0] f_m1;
        logic [4:0] k_m1;
        logic [7:0] m_m1;
        logic [1:0] cs;
        logic [4:0] n_m1;
        logic [4:0] np_m1;
        logic [2:0] subclass;
        logic [2:0] jesdv;
        logic [4:0] s_m1;
        logic       hd;
        logic [4:0] cf;
    } link_cfg_t;

    function automatic lane_sym_t mk_sym(logic [7:0] o, logic k, logic last);
        lane_sym_t s;
        s.octet   = o;
        s.is_k    = k;
        s.mf_last = last;
        return s;
    endfunction

    // Sum of field values, not of packed octets.
    function automatic logic [7:0] cfg_sum(link_cfg_t c);
        logic [7:0] s;
        s = c.did + 8'(c.bid) + 8'(c.lid) + 8'(c.scr) + 8'(c.l_m1)
          + c.f_m1 + 8'(c.k_m1) + c.m_m1 + 8'(c.cs) + 8'(c.n_m1)
          + 8'(c.np_m1) + 8'(c.subclass) + 8'(c.jesdv) + 8'(c.s_m1)
          + 8'(c.hd) + 8'(c.cf);
        return s;
    endfunction

    function automatic logic [7:0] cfg_octet(link_cfg_t c, logic [3:0] idx);
        logic [7:0] o;
        case (idx)
            4'd0:    o = c.did;
            4'd1:    o = {4'h0, c.bid};
            4'd2:    o = {3'b000, c.lid};
            4'd3:    o = {c.scr, 2'b00, c.l_m1};
            4'd4:    o = c.f_m1;
            4'd5:    o = {3'b000, c.k_m1};
            4'd6:    o = c.m_m1;
            4'd7:    o = {c.cs, 1'b0, c.n_m1};
            4'd8:    o = {c.subclass, c.np_m1};
            4'd9:    o = {c.jesdv, c.s_m1};
            4'd10:   o = {c.hd, 2'b00, c.cf};
            4'd13:   o = cfg_sum(c);
            default: o = 8'h00;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/jlss_lmfc.sv
module jlss_lmfc #(
    parameter int F_W = 8,
    parameter int K_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           lmfc_force,
    input  logic [K_W-1:0] lmfc_init,
    input  logic [F_W-1:0] f_m1,
    input  logic [K_W-1:0] k_m1,
    output logic           mf_end
);
    logic [F_W-1:0] oct_q;
    logic [K_W-1:0] frm_q;
    logic           frame_end;

    assign frame_end = (oct_q == f_m1);
    assign mf_end    = frame_end && (frm_q == k_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            oct_q <= '0;
            frm_q <= lmfc_force ? lmfc_init : '0;
        end else if (frame_end) begin
            oct_q <= '0;
            frm_q <= (frm_q == k_m1) ? '0 : frm_q + 1'b1;
        end else begin
            oct_q <= oct_q + 1'b1;
        end
    end
endmodule

// File: rtl/jlss_cfg_block.sv
module jlss_cfg_block
    import jlss_pkg::*;
(
    input  link_cfg_t  cfg,
    input  logic [3:0] sel,
    output logic [7:0] octet
);
    logic [7:0] tbl [CFG_OCTETS];

    for (genvar g = 0; g < CFG_OCTETS; g++) begin : g_oct
        assign tbl[g] = cfg_octet(cfg, 4'(g));
    end

    always_comb begin
        octet = 8'h00;
        if (int'(sel) < CFG_OCTETS) octet = tbl[sel];
    end
endmodule

// File: rtl/jlss_seq.sv
module jlss_seq
    import jlss_pkg::*;
#(
    parameter int F_W = 8,
    parameter int K_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sync_n,
    input  logic           ila_off,
    input  logic           idle_alt,
    input  logic [1:0]     ila_delay,
    input  logic [F_W-1:0] f_m1,
    input  logic           mf_end,
    input  logic [7:0]     data_in,
    input  logic [7:0]     cfg_oct,
    output logic [3:0]     cfg_sel,
    output seq_st_e        state,
    output lane_sym_t      sym
);
    localparam int IDX_W = F_W + K_W;

    seq_st_e        st_q, st_n;
    logic [1:0]     wait_q, wait_n;
    logic [1:0]     mfn_q, mfn_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic [F_W-1:0] low_q, low_n;
    logic           ph_q, ph_n;
    logic           resync;
    logic           in_cfg;

    assign state  = st_q;
    assign resync = !sync_n && (st_q != SQ_CGS) && (low_q == f_m1);
    assign in_cfg = (idx_q >= IDX_W'(CFG_FIRST)) && (idx_q <= IDX_W'(CFG_LAST));
    assign cfg_sel = idx_q[3:0] - 4'(CFG_FIRST);

    always_comb begin
        st_n   = st_q;
        wait_n = wait_q;
        mfn_n  = mfn_q;
        idx_n  = idx_q;
        ph_n   = 1'b0;
        low_n  = (st_q == SQ_CGS || sync_n || low_q == f_m1) ? '0 : low_q + 1'b1;
        case (st_q)
            SQ_CGS: begin
                ph_n = ~ph_q;
                if (sync_n) begin
                    st_n   = SQ_WAIT;
                    wait_n = 2'd0;
                end
            end
            SQ_WAIT: begin
                ph_n = ~ph_q;
                if (mf_end) begin
                    if (wait_q == ila_delay) begin
                        st_n  = ila_off ? SQ_DATA : SQ_ILA;
                        mfn_n = 2'd0;
                        idx_n = '0;
                    end else begin
                        wait_n = wait_q + 2'd1;
                    end
                end
            end
            SQ_ILA: begin
                idx_n = idx_q + 1'b1;
                if (mf_end) begin
                    idx_n = '0;
                    if (mfn_q == 2'(ILA_MFS - 1)) st_n = SQ_DATA;
                    else                          mfn_n = mfn_q + 2'd1;
                end
            end
            default: ;
        endcase
        if (resync) begin
            st_n = SQ_CGS;
            ph_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_CGS;
            wait_q <= 2'd0;
            mfn_q  <= 2'd0;
            idx_q  <= '0;
            low_q  <= '0;
            ph_q   <= 1'b0;
        end else begin
            st_q   <= st_n;
            wait_q <= wait_n;
            mfn_q  <= mfn_n;
            idx_q  <= idx_n;
            low_q  <= low_n;
            ph_q   <= ph_n;
        end
    end

    always_comb begin
        case (st_q)
            SQ_CGS, SQ_WAIT: begin
                if (idle_alt && ph_q) sym = mk_sym(IDLE_PAIR, 1'b0, mf_end);
                else                  sym = mk_sym(K_COMMA, 1'b1, mf_end);
            end
            SQ_ILA: begin
                if (idx_q == '0)
                    sym = mk_sym(K_MF_OPEN, 1'b1, mf_end);
                else if (mf_end)
                    sym = mk_sym(K_MF_CLOSE, 1'b1, mf_end);
                else if (mfn_q == 2'd1 && idx_q == IDX_W'(1))
                    sym = mk_sym(K_CFG_MARK, 1'b1, mf_end);
                else if (mfn_q == 2'd1 && in_cfg)
                    sym = mk_sym(cfg_oct, 1'b0, mf_end);
                else
                    sym = mk_sym(data_in, 1'b0, mf_end);
            end
            default: sym = mk_sym(data_in, 1'b0, mf_end);
        endcase
    end
endmodule

// File: rtl/jlss_link_seq.sv
module jlss_link_seq
    import jlss_pkg::*;
#(
    parameter int F_W = 8,
    parameter int K_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sync_n,
    input  logic [7:0]     data_in,
    input  logic           ila_off,
    input  logic           idle_alt,
    input  logic [1:0]     ila_delay,
    input  logic           lmfc_force,
    input  logic [K_W-1:0] lmfc_init,
    input  logic [F_W-1:0] cfg_f_m1,
    input  logic [K_W-1:0] cfg_k_m1,
    input  logic [7:0]     cfg_did,
    input  logic [3:0]     cfg_bid,
    input  logic [4:0]     cfg_lid,
    input  logic           cfg_scr,
    input  logic [4:0]     cfg_l_m1,
    input  logic [7:0]     cfg_m_m1,
    input  logic [1:0]     cfg_cs,
    input  logic [4:0]     cfg_n_m1,
    input  logic [4:0]     cfg_np_m1,
    input  logic [2:0]     cfg_subclass,
    input  logic [2:0]     cfg_jesdv,
    input  logic [4:0]     cfg_s_m1,
    input  logic           cfg_hd,
    input  logic [4:0]     cfg_cf,
    output logic [7:0]     tx_octet,
    output logic           tx_is_k,
    output logic           tx_mf_last
);
    link_cfg_t  cfg;
    logic       mf_end;
    logic [3:0] cfg_sel;
    logic [7:0] cfg_oct;
    seq_st_e    seq_state;
    lane_sym_t  sym, sym_q;

    always_comb begin
        cfg          = '0;
        cfg.did      = cfg_did;
        cfg.bid      = cfg_bid;
        cfg.lid      = cfg_lid;
        cfg.scr      = cfg_scr;
        cfg.l_m1     = cfg_l_m1;
        cfg.f_m1     = 8'(cfg_f_m1);
        cfg.k_m1     = 5'(cfg_k_m1);
        cfg.m_m1     = cfg_m_m1;
        cfg.cs       = cfg_cs;
        cfg.n_m1     = cfg_n_m1;
        cfg.np_m1    = cfg_np_m1;
        cfg.subclass = cfg_subclass;
        cfg.jesdv    = cfg_jesdv;
        cfg.s_m1     = cfg_s_m1;
        cfg.hd       = cfg_hd;
        cfg.cf       = cfg_cf;
    end

    jlss_lmfc #(.F_W(F_W), .K_W(K_W)) u_lmfc (
        .clk        (clk),
        .rst        (rst),
        .lmfc_force (lmfc_force),
        .lmfc_init  (lmfc_init),
        .f_m1       (cfg_f_m1),
        .k_m1       (cfg_k_m1),
        .mf_end     (mf_end)
    );

    jlss_cfg_block u_cfg (
        .cfg   (cfg),
        .sel   (cfg_sel),
        .octet (cfg_oct)
    );

    jlss_seq #(.F_W(F_W), .K_W(K_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sync_n    (sync_n),
        .ila_off   (ila_off),
        .idle_alt  (idle_alt),
        .ila_delay (ila_delay),
        .f_m1      (cfg_f_m1),
        .mf_end    (mf_end),
        .data_in   (data_in),
        .cfg_oct   (cfg_oct),
        .cfg_sel   (cfg_sel),
        .state     (seq_state),
        .sym       (sym)
    );

    always_ff @(posedge clk) begin
        if (rst) sym_q <= mk_sym(K_COMMA, 1'b1, 1'b0);
        else     sym_q <= sym;
    end

    assign tx_octet   = sym_q.octet;
    assign tx_is_k    = sym_q.is_k;
    assign tx_mf_last = sym_q.mf_last;
endmodule

// File: rtl/jlss_link_seq_chk.sv
module jlss_link_seq_chk
    import jlss_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ila_off,
    input logic       idle_alt,
    input seq_st_e    st,
    input logic       mf_end,
    input logic [7:0] tx_octet,
    input logic       tx_is_k,
    input logic       tx_mf_last
);
    p_comma_r1: assert property (@(posedge clk) disable iff (rst)
        ((st == SQ_CGS || st == SQ_WAIT) && !idle_alt) |=> (tx_is_k && tx_octet == K_COMMA));

    p_idle_code_r2: assert property (@(posedge clk) disable iff (rst)
        ((st == SQ_CGS || st == SQ_WAIT) && idle_alt) |=>
            ((tx_is_k && tx_octet == K_COMMA) || (!tx_is_k && tx_octet == IDLE_PAIR)));

    p_ila_on_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_ILA && $past(st) == SQ_WAIT) |-> $past(mf_end));

    p_ila_opens_r4: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_ILA && $past(st) != SQ_ILA) |=> (tx_is_k && tx_octet == K_MF_OPEN));

    p_ila_gated_r8: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_ILA && $past(st) == SQ_WAIT) |-> !$past(ila_off));

    p_mf_flag_r9: assert property (@(posedge clk) disable iff (rst)
        mf_end |=> tx_mf_last);

    p_data_plain_r11: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_DATA) |=> !tx_is_k);
endmodule

bind jlss_link_seq jlss_link_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ila_off    (ila_off),
    .idle_alt   (idle_alt),
    .st         (seq_state),
    .mf_end     (mf_end),
    .tx_octet   (tx_octet),
    .tx_is_k    (tx_is_k),
    .tx_mf_last (tx_mf_last)
);

// File: tb/jlss_link_seq_tb.sv
module jlss_link_seq_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, sync_n = 1'b0, ila_off = 1'b0, idle_alt = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [1:0] ila_delay = 2'd0;
    logic       lmfc_force = 1'b0;
    logic [4:0] lmfc_init = 5'd0;
    logic [7:0] cfg_f_m1 = 8'd0;
    logic [4:0] cfg_k_m1 = 5'd0;
    logic [7:0] cfg_did = 0, cfg_m_m1 = 0;
    logic [3:0] cfg_bid = 0;
    logic [4:0] cfg_lid = 0, cfg_l_m1 = 0, cfg_n_m1 = 0, cfg_np_m1 = 0, cfg_s_m1 = 0, cfg_cf = 0;
    logic       cfg_scr = 0, cfg_hd = 0;
    logic [1:0] cfg_cs = 0;
    logic [2:0] cfg_subclass = 0, cfg_jesdv = 0;
    logic [7:0] tx_octet;
    logic       tx_is_k, tx_mf_last;

    jlss_link_seq u_dut (.*);

    int total = 0, bad = 0, n = 0, fk = 1, init_fr = 0, fr = 1;
    bit done = 0;

    function automatic logic [7:0] dpat(int p);
        return 8'((p * 37 + 11) & 255);
    endfunction

    function automatic int lin(int p);
        return (init_fr * fr + p) % fk;
    endfunction

    function automatic logic [7:0] exp_cfg(int i);
        logic [7:0] s;
        case (i)
            0: return cfg_did;
            1: return {4'h0, cfg_bid};
            2: return {3'b0, cfg_lid};
            3: return {cfg_scr, 2'b0, cfg_l_m1};
            4: return cfg_f_m1;
            5: return {3'b0, cfg_k_m1};
            6: return cfg_m_m1;
            7: return {cfg_cs, 1'b0, cfg_n_m1};
            8: return {cfg_subclass, cfg_np_m1};
            9: return {cfg_jesdv, cfg_s_m1};
            10: return {cfg_hd, 2'b0, cfg_cf};
            13: begin
                s = 8'((int'(cfg_did) + int'(cfg_bid) + int'(cfg_lid) + int'(cfg_scr)
                      + int'(cfg_l_m1) + int'(cfg_f_m1) + int'(cfg_k_m1) + int'(cfg_m_m1)
                      + int'(cfg_cs) + int'(cfg_n_m1) + int'(cfg_np_m1) + int'(cfg_subclass)
                      + int'(cfg_jesdv) + int'(cfg_s_m1) + int'(cfg_hd) + int'(cfg_cf)) % 256);
                return s;
            end
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, int p, logic [7:0] eo, logic ek, logic el);
        total++;
        if (tx_octet !== eo || tx_is_k !== ek || tx_mf_last !== el) begin
            bad++;
            $display("FAIL %s pos=%0d actual=%02h k=%0b last=%0b expected=%02h k=%0b last=%0b",
                     tag, p, tx_octet, tx_is_k, tx_mf_last, eo, ek, el);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n++;
        data_in = dpat(n);
    endtask

    task automatic sync_code(int ph, output logic [7:0] o, output logic k);
        if (idle_alt && ph[0]) begin o = 8'h50; k = 1'b0; end
        else begin o = 8'hBC; k = 1'b1; end
    endtask

    task automatic run(int f, int k, int ini, int dly, bit off, bit idle, int cgs_len, bit frc);
        int r, s, e, j, p, a, c;
        logic [7:0] eo; logic ek; bit last;
        string tag;
        fr = f; fk = f * k; init_fr = frc ? ini : 0;
        cfg_f_m1 = 8'(f - 1); cfg_k_m1 = 5'(k - 1);
        lmfc_force = frc; lmfc_init = 5'(ini);
        ila_delay = 2'(dly); ila_off = off; idle_alt = idle;
        rst = 1'b1; sync_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset", -1, 8'hBC, 1'b1, 1'b0);
        rst = 1'b0; n = 0; data_in = dpat(0);
        for (int i = 0; i < cgs_len; i++) begin
            step(); p = n - 1;
            sync_code(p, eo, ek);
            chk(idle ? "R2 cgs" : "R1 cgs", p, eo, ek, lin(p) == fk - 1);
        end
        sync_n = 1'b1;
        r = n + 1;
        j = r + 1;
        while (lin(j) != 0) j++;
        s = j + dly * fk;
        e = off ? s : s + 4 * fk;
        while (n - 1 < e + fk + 3) begin
            step(); p = n - 1; last = (lin(p) == fk - 1);
            if (p < s) begin
                sync_code(p, eo, ek);
                tag = idle ? "R2 wait" : "R3 wait";
            end else if (p < e) begin
                int m, i;
                m = (p - s) / fk; i = (p - s) % fk;
                if (i == 0) begin eo = 8'h1C; ek = 1; tag = "R3 R4 open"; end
                else if (i == fk - 1) begin eo = 8'h7C; ek = 1; tag = "R4 close"; end
                else if (m == 1 && i == 1) begin eo = 8'h9C; ek = 1; tag = "R5 mark"; end
                else if (m == 1 && i >= 2 && i <= 15) begin
                    eo = exp_cfg(i - 2); ek = 0;
                    tag = (i == 15) ? "R7 checksum" : "R6 cfg";
                end else begin eo = dpat(p); ek = 0; tag = "R4 filler"; end
            end else begin
                eo = dpat(p); ek = 0;
                tag = off ? "R8 data" : "R11 data";
            end
            chk(tag, p, eo, ek, last);
            if (last !== tx_mf_last) $display("note R9 boundary mismatch at %0d", p);
        end
        if (f > 1) begin
            sync_n = 1'b0;
            for (int i = 0; i < f - 1; i++) begin
                step(); p = n - 1;
                chk("R10 short low", p, dpat(p), 1'b0, lin(p) == fk - 1);
            end
            sync_n = 1'b1;
            repeat (2) begin
                step(); p = n - 1;
                chk("R10 short low", p, dpat(p), 1'b0, lin(p) == fk - 1);
            end
        end
        sync_n = 1'b0;
        a = n + 1;
        c = a + f - 1;
        repeat (f + 4) begin
            step(); p = n - 1;
            if (p < c) begin eo = dpat(p); ek = 0; end
            else sync_code(p - c, eo, ek);
            chk("R10 resync", p, eo, ek, lin(p) == fk - 1);
        end
    endtask

    task automatic rand_cfg();
        cfg_did = 8'($urandom); cfg_bid = 4'($urandom); cfg_lid = 5'($urandom);
        cfg_scr = 1'($urandom); cfg_l_m1 = 5'($urandom); cfg_m_m1 = 8'($urandom);
        cfg_cs = 2'($urandom); cfg_n_m1 = 5'($urandom); cfg_np_m1 = 5'($urandom);
        cfg_subclass = 3'($urandom); cfg_jesdv = 3'($urandom); cfg_s_m1 = 5'($urandom);
        cfg_hd = 1'($urandom); cfg_cf = 5'($urandom);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4242);
        rand_cfg();
        run(2, 9, 0, 0, 0, 0, 5, 0);
        run(1, 17, 16, 3, 0, 1, 30, 1);
        run(4, 8, 3, 1, 1, 0, 12, 1);
        cfg_did = 8'hFF; cfg_m_m1 = 8'hFF; cfg_bid = 4'hF; cfg_lid = 5'h1F;
        cfg_cf = 5'h1F; cfg_s_m1 = 5'h1F; cfg_n_m1 = 5'h1F; cfg_np_m1 = 5'h1F;
        run(3, 6, 5, 2, 0, 1, 7, 1);
        for (int t = 0; t < 8; t++) begin
            int f, kmin, k;
            rand_cfg();
            f = 1 + int'($urandom % 4);
            kmin = (17 + f - 1) / f;
            k = kmin + int'($urandom % (33 - kmin));
            run(f, k, int'($urandom % k), int'($urandom % 4), ($urandom % 4) == 0,
                1'($urandom), 2 + int'($urandom % 40), 1'($urandom));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule